// File: doc/BRIEF.md
# Multi-Bank SDRAM Command Timing Checker

This block sits beside an SDRAM controller and watches its decoded command stream. Each command arrives as a 3-bit code together with a 2-bit bank number and an auto-precharge flag. For each of the four banks the checker keeps an open/closed flag, a count of the cycles since that bank was activated, and several down-counters. These record how long remains before activate, precharge or write recovery is allowed again. A few bus-wide counters cover activate-to-activate spacing across banks, the auto-refresh busy window and the mode-write busy window.

Every minimum and maximum spacing rule has its own bit in a violation vector. The vector is registered: it shows the verdict on the command of the previous cycle and clears when the next verdict arrives. A companion bit reports whether that command was legal. The checker never blocks or alters a command, and its bank state always follows the commands as issued. All spacings are cycle-count parameters whose defaults suit a 250 MHz clock. A user adjusts them for another clock rate or burst length.

Top module: `sdram_cmd_checker`

## Requirements
- R1: After reset the violation vector is all zero and the command-legal output is 1.
- R2: Command codes are NOP=0, ACTIVATE=1, READ=2, WRITE=3, PRECHARGE=4, PRECHARGE-ALL=5, REFRESH=6, MODE-WRITE=7. A READ or WRITE to a closed bank, or an ACTIVATE to an open bank, sets violation bit 0.
- R3: A READ fewer than T_RCD_RD (default 4) cycles after its bank's ACTIVATE sets bit 1. A WRITE fewer than T_RCD_WR (default 2) cycles after it also sets bit 1.
- R4: A PRECHARGE or PRECHARGE-ALL that closes an open bank fewer than T_RAS (default 9) cycles after its ACTIVATE sets bit 2. Precharging a closed bank is ignored and sets no bit.
- R5: Bit 3 is set for every cycle in which a bank has been open for more than T_RAS_MAX cycles, whatever the command.
- R6: An ACTIVATE to a bank sets bit 4 in three cases. The first is fewer than T_RP (default 4) cycles after the PRECHARGE that closed the bank. The second is fewer than BURST_CYC+T_RP (default 6) cycles after a READ with auto-precharge. The third is fewer than T_DAL (default 7) cycles after a WRITE with auto-precharge.
- R7: An ACTIVATE fewer than T_RC (default 13) cycles after the previous ACTIVATE of the same bank sets bit 5.
- R8: Any ACTIVATE fewer than T_RRD (default 3) cycles after any earlier ACTIVATE sets bit 6.
- R9: A precharge that closes a bank fewer than BURST_CYC+T_WR (default 5) cycles after a WRITE to that bank sets bit 7.
- R10: Bit 8 is set by a REFRESH issued while any bank is open or still inside its precharge window. It is also set by any non-NOP command fewer than T_RFC (default 15) cycles after a REFRESH.
- R11: Bit 9 is set by a MODE-WRITE issued while any bank is open or still inside its precharge window. It is also set by any non-NOP command fewer than T_MRD (default 2) cycles after a MODE-WRITE.
- R12: The verdict on a command appears on the outputs in the cycle after the command and lasts exactly one cycle. In that cycle the command-legal output is 0 exactly when one of bits 0-2 or 4-9 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; commands are sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_i | input | 3 | Decoded command code |
| bank_i | input | 2 | Bank addressed by the command |
| ap_i | input | 1 | Auto-precharge flag for READ and WRITE |
| viol_o | output | 10 | Registered per-rule violation vector |
| cmd_ok_o | output | 1 | Registered: the previous command broke no command rule |

## Verification
The hardest situations to reach from the ports are the maximum-open-time overrun and the recovery windows that stack behind one another. Auto-precharge recovery starts only after a legal activate and write. The row-cycle window overlaps the precharge window and ends at the same cycle under the defaults. The bench shortens the open-time limit to 40 cycles and leaves every other spacing at its default. For each rule it first builds a clean prefix of legal commands. It then sweeps the gap to the offending command across the limit and checks only that rule's bit.

// File: rtl/sdram_chk_pkg.sv
package sdram_chk_pkg;

  typedef enum logic [2:0] {
    CMD_NOP  = 3'd0,
    CMD_ACT  = 3'd1,
    CMD_RD   = 3'd2,
    CMD_WR   = 3'd3,
    CMD_PRE  = 3'd4,
    CMD_PREA = 3'd5,
    CMD_REF  = 3'd6,
    CMD_MODE = 3'd7
  } cmd_e;

  localparam int V_STATE   = 0;
  localparam int V_RCD     = 1;
  localparam int V_RAS_MIN = 2;
  localparam int V_RAS_MAX = 3;
  localparam int V_RP      = 4;
  localparam int V_RC      = 5;
  localparam int V_RRD     = 6;
  localparam int V_WR      = 7;
  localparam int V_REF     = 8;
  localparam int V_MRD     = 9;
  localparam int NV        = 10;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdram_bank_track.sv
module sdram_bank_track
  import sdram_chk_pkg::*;
#(
  parameter int T_RC      = 13,
  parameter int T_RAS     = 9,
  parameter int T_RAS_MAX = 25000,
  parameter int T_RCD_RD  = 4,
  parameter int T_RCD_WR  = 2,
  parameter int T_RP      = 4,
  parameter int T_DAL     = 7,
  parameter int T_WR      = 3,
  parameter int BURST_CYC = 2,
  parameter int SW        = 16,
  parameter int DW        = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  cmd_e          cmd_i,
  input  logic          hit_i,
  input  logic          ap_i,
  output logic          idle_o,
  output logic [NV-1:0] viol_o
);

  localparam int SAT    = T_RAS_MAX + 1;
  localparam int RD_AP  = BURST_CYC + T_RP;
  localparam int WR_REC = BURST_CYC + T_WR;

  logic          open_q, open_d;
  logic [SW-1:0] since_q, since_d;
  logic [DW-1:0] rc_q, rc_d;
  logic [DW-1:0] rp_q, rp_d;
  logic [DW-1:0] wr_q, wr_d;
  logic          close_req;

  always_comb begin
    open_d    = open_q;
    since_d   = (since_q == SW'(SAT)) ? since_q : since_q + 1'b1;
    rc_d      = (rc_q != '0) ? rc_q - 1'b1 : rc_q;
    rp_d      = (rp_q != '0) ? rp_q - 1'b1 : rp_q;
    wr_d      = (wr_q != '0) ? wr_q - 1'b1 : wr_q;
    viol_o    = '0;
    close_req = (cmd_i == CMD_PREA) || (cmd_i == CMD_PRE && hit_i);

    if (open_q && since_q > SW'(T_RAS_MAX)) viol_o[V_RAS_MAX] = 1'b1;

    unique case (cmd_i)
      CMD_ACT: if (hit_i) begin
        if (open_q)     viol_o[V_STATE] = 1'b1;
        if (rc_q != '0) viol_o[V_RC]    = 1'b1;
        if (rp_q != '0) viol_o[V_RP]    = 1'b1;
        open_d  = 1'b1;
        since_d = SW'(1);
        rc_d    = DW'(T_RC - 1);
      end
      CMD_RD: if (hit_i) begin
        if (!open_q) viol_o[V_STATE] = 1'b1;
        else if (since_q < SW'(T_RCD_RD)) viol_o[V_RCD] = 1'b1;
        if (open_q && ap_i) begin
          open_d = 1'b0;
          rp_d   = DW'(RD_AP - 1);
        end
      end
      CMD_WR: if (hit_i) begin
        if (!open_q) viol_o[V_STATE] = 1'b1;
        else if (since_q < SW'(T_RCD_WR)) viol_o[V_RCD] = 1'b1;
        if (open_q) begin
          wr_d = DW'(WR_REC - 1);
          if (ap_i) begin
            open_d = 1'b0;
            rp_d   = DW'(T_DAL - 1);
          end
        end
      end
      CMD_PRE, CMD_PREA: if (close_req && open_q) begin
        if (since_q < SW'(T_RAS)) viol_o[V_RAS_MIN] = 1'b1;
        if (wr_q != '0)           viol_o[V_WR]      = 1'b1;
        open_d = 1'b0;
        rp_d   = DW'(T_RP - 1);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q  <= 1'b0;
      since_q <= '0;
      rc_q    <= '0;
      rp_q    <= '0;
      wr_q    <= '0;
    end else begin
      open_q  <= open_d;
      since_q <= since_d;
      rc_q    <= rc_d;
      rp_q    <= rp_d;
      wr_q    <= wr_d;
    end
  end

  assign idle_o = !open_q && (rp_q == '0);

  a_r2_act_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == CMD_ACT && hit_i) |=> open_q);
  a_r4_prea_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == CMD_PREA) |=> !open_q);
  a_r5_age_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    since_q <= SW'(SAT));
  a_r6_closed_after_pre: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == CMD_PRE && hit_i) |=> !open_q);

endmodule

// File: rtl/sdram_bus_track.sv
module sdram_bus_track
  import sdram_chk_pkg::*;
#(
  parameter int T_RRD = 3,
  parameter int T_RFC = 15,
  parameter int T_MRD = 2,
  parameter int GW    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  cmd_e          cmd_i,
  input  logic          all_idle_i,
  output logic [NV-1:0] viol_o
);

  logic [GW-1:0] rrd_q, rrd_d;
  logic [GW-1:0] rfc_q, rfc_d;
  logic [GW-1:0] mrd_q, mrd_d;
  logic          busy_cmd;

  always_comb begin
    rrd_d    = (rrd_q != '0) ? rrd_q - 1'b1 : rrd_q;
    rfc_d    = (rfc_q != '0) ? rfc_q - 1'b1 : rfc_q;
    mrd_d    = (mrd_q != '0) ? mrd_q - 1'b1 : mrd_q;
    viol_o   = '0;
    busy_cmd = (cmd_i != CMD_NOP);

    if (busy_cmd && rfc_q != '0) viol_o[V_REF] = 1'b1;
    if (busy_cmd && mrd_q != '0) viol_o[V_MRD] = 1'b1;

    unique case (cmd_i)
      CMD_ACT: begin
        if (rrd_q != '0) viol_o[V_RRD] = 1'b1;
        rrd_d = GW'(T_RRD - 1);
      end
      CMD_REF: begin
        if (!all_idle_i) viol_o[V_REF] = 1'b1;
        rfc_d = GW'(T_RFC - 1);
      end
      CMD_MODE: begin
        if (!all_idle_i) viol_o[V_MRD] = 1'b1;
        mrd_d = GW'(T_MRD - 1);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rrd_q <= '0;
      rfc_q <= '0;
      mrd_q <= '0;
    end else begin
      rrd_q <= rrd_d;
      rfc_q <= rfc_d;
      mrd_q <= mrd_d;
    end
  end

  a_r10_refresh_arms: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == CMD_REF) |=> (rfc_q == GW'(T_RFC - 1)));
  a_r11_mode_arms: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == CMD_MODE) |=> (mrd_q == GW'(T_MRD - 1)));

endmodule

// File: rtl/sdram_cmd_checker.sv
module sdram_cmd_checker
  import sdram_chk_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int T_RC      = 13,
  parameter int T_RFC     = 15,
  parameter int T_RAS     = 9,
  parameter int T_RAS_MAX = 25000,
  parameter int T_RCD_RD  = 4,
  parameter int T_RCD_WR  = 2,
  parameter int T_RP      = 4,
  parameter int T_RRD     = 3,
  parameter int T_DAL     = 7,
  parameter int T_WR      = 3,
  parameter int T_MRD     = 2,
  parameter int BURST_CYC = 2,
  localparam int BW       = $clog2(NUM_BANKS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    cmd_i,
  input  logic [BW-1:0] bank_i,
  input  logic          ap_i,
  output logic [NV-1:0] viol_o,
  output logic          cmd_ok_o
);

  localparam int SW = $clog2(T_RAS_MAX + 2);
  localparam int DMAX = imax(imax(T_RC, T_DAL), imax(BURST_CYC + T_RP, BURST_CYC + T_WR));
  localparam int DW = $clog2(DMAX + 1);
  localparam int GW = $clog2(imax(imax(T_RRD, T_RFC), T_MRD) + 1);
  localparam logic [NV-1:0] CMD_MASK = ~(NV'(1) << V_RAS_MAX);

  logic [1:0]    rst_sync_q;
  logic          rst_s_n;
  cmd_e          cmd;
  logic [NV-1:0] bank_viol [NUM_BANKS];
  logic [NUM_BANKS-1:0] bank_idle;
  logic [NV-1:0] bus_viol;
  logic [NV-1:0] viol_d;
  logic          ok_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  assign cmd = cmd_e'(cmd_i);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    sdram_bank_track #(
      .T_RC(T_RC), .T_RAS(T_RAS), .T_RAS_MAX(T_RAS_MAX),
      .T_RCD_RD(T_RCD_RD), .T_RCD_WR(T_RCD_WR), .T_RP(T_RP),
      .T_DAL(T_DAL), .T_WR(T_WR), .BURST_CYC(BURST_CYC),
      .SW(SW), .DW(DW)
    ) u_bank (
      .clk    (clk),
      .rst_n  (rst_s_n),
      .cmd_i  (cmd),
      .hit_i  (bank_i == BW'(b)),
      .ap_i   (ap_i),
      .idle_o (bank_idle[b]),
      .viol_o (bank_viol[b])
    );
  end

  sdram_bus_track #(
    .T_RRD(T_RRD), .T_RFC(T_RFC), .T_MRD(T_MRD), .GW(GW)
  ) u_bus (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .cmd_i      (cmd),
    .all_idle_i (&bank_idle),
    .viol_o     (bus_viol)
  );

  always_comb begin
    viol_d = bus_viol;
    for (int b = 0; b < NUM_BANKS; b++) viol_d = viol_d | bank_viol[b];
    ok_d = ~|(viol_d & CMD_MASK);
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      viol_o   <= '0;
      cmd_ok_o <= 1'b1;
    end else begin
      viol_o   <= viol_d;
      cmd_ok_o <= ok_d;
    end
  end

  a_r8_rrd_from_act: assert property (@(posedge clk) disable iff (!rst_s_n)
    viol_o[V_RRD] |-> ($past(cmd_i) == CMD_ACT));
  a_r12_state_not_ok: assert property (@(posedge clk) disable iff (!rst_s_n)
    viol_o[V_STATE] |-> !cmd_ok_o);
  a_r11_mrd_needs_cmd: assert property (@(posedge clk) disable iff (!rst_s_n)
    viol_o[V_MRD] |-> ($past(cmd_i) != CMD_NOP));
  a_r3_rcd_needs_col: assert property (@(posedge clk) disable iff (!rst_s_n)
    viol_o[V_RCD] |-> ($past(cmd_i) == CMD_RD || $past(cmd_i) == CMD_WR));

endmodule

// File: tb/sdram_cmd_checker_test.sv
module sdram_cmd_checker_test;

  localparam int NOP = 0, ACT = 1, RD = 2, WR = 3, PRE = 4, PREA = 5, REF = 6, MODE = 7;
  localparam int RAS_MAX_TB = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] cmd_i = 3'd0;
  logic [1:0] bank_i = 2'd0;
  logic       ap_i = 1'b0;
  logic [9:0] viol_o;
  logic       cmd_ok_o;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sdram_cmd_checker #(.T_RAS_MAX(RAS_MAX_TB)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .bank_i(bank_i), .ap_i(ap_i),
    .viol_o(viol_o), .cmd_ok_o(cmd_ok_o)
  );

  task automatic check(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic issue(input int c, input int b, input bit a);
    cmd_i  = 3'(c);
    bank_i = 2'(b);
    ap_i   = a;
    @(negedge clk);
    cmd_i  = 3'd0;
    ap_i   = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) issue(NOP, 0, 1'b0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    do_reset();
    check("R1 viol", int'(viol_o), 0);
    check("R1 ok", int'(cmd_ok_o), 1);

    // R2 state rules
    issue(RD, 1, 1'b0);  check("R2 read closed", int'(viol_o[0]), 1);
    issue(WR, 2, 1'b0);  check("R2 write closed", int'(viol_o[0]), 1);
    issue(ACT, 3, 1'b0); check("R2 first act", int'(viol_o[0]), 0);
    idle(20);
    issue(ACT, 3, 1'b0); check("R2 act open", int'(viol_o[0]), 1);
    check("R12 ok low", int'(cmd_ok_o), 0);
    idle(1);
    check("R12 clears", int'(viol_o), 0);

    // R3 activate-to-column sweeps
    for (int d = 1; d <= 6; d++) begin
      do_reset(); issue(ACT, 0, 1'b0); idle(d - 1); issue(RD, 0, 1'b0);
      check("R3 read gap", int'(viol_o[1]), int'(d < 4));
      check("R12 read ok", int'(cmd_ok_o), int'(d >= 4));
      do_reset(); issue(ACT, 0, 1'b0); idle(d - 1); issue(WR, 0, 1'b0);
      check("R3 write gap", int'(viol_o[1]), int'(d < 2));
    end

    // R4 minimum open time, and precharge of closed bank ignored
    for (int d = 1; d <= 11; d++) begin
      do_reset(); issue(ACT, 0, 1'b0); idle(d - 1); issue(PRE, 0, 1'b0);
      check("R4 pre gap", int'(viol_o[2]), int'(d < 9));
    end
    for (int d = 5; d <= 9; d += 4) begin
      do_reset(); issue(ACT, 1, 1'b0); idle(d - 1); issue(PREA, 0, 1'b0);
      check("R4 prea gap", int'(viol_o[2]), int'(d < 9));
    end
    do_reset(); issue(PRE, 2, 1'b0);
    check("R4 idle pre viol", int'(viol_o), 0);
    check("R4 idle pre ok", int'(cmd_ok_o), 1);

    // R5 maximum open time
    do_reset(); issue(ACT, 0, 1'b0);
    for (int k = 1; k <= RAS_MAX_TB + 4; k++) begin
      issue(NOP, 0, 1'b0);
      check("R5 age", int'(viol_o[3]), int'(k > RAS_MAX_TB));
    end
    check("R5 ok unaffected", int'(cmd_ok_o), 1);
    issue(PRE, 0, 1'b0); idle(1);
    check("R5 cleared", int'(viol_o[3]), 0);

    // R6 precharge recovery: explicit, read-AP, write-AP
    for (int d = 1; d <= 8; d++) begin
      do_reset(); issue(ACT, 0, 1'b0); idle(9); issue(PRE, 0, 1'b0);
      idle(d - 1); issue(ACT, 0, 1'b0);
      check("R6 pre-act", int'(viol_o[4]), int'(d < 4));
      do_reset(); issue(ACT, 0, 1'b0); idle(4); issue(RD, 0, 1'b1);
      idle(d - 1); issue(ACT, 0, 1'b0);
      check("R6 rdap-act", int'(viol_o[4]), int'(d < 6));
      do_reset(); issue(ACT, 0, 1'b0); idle(4); issue(WR, 0, 1'b1);
      idle(d - 1); issue(ACT, 0, 1'b0);
      check("R6 wrap-act", int'(viol_o[4]), int'(d < 7));
    end

    // R7 row cycle
    for (int t = 10; t <= 15; t++) begin
      do_reset(); issue(ACT, 0, 1'b0); idle(8); issue(PRE, 0, 1'b0);
      idle(t - 10); issue(ACT, 0, 1'b0);
      check("R7 act-act", int'(viol_o[5]), int'(t < 13));
    end

    // R8 activate spacing across banks
    for (int d = 1; d <= 5; d++) begin
      do_reset(); issue(ACT, 0, 1'b0); idle(d - 1); issue(ACT, 1, 1'b0);
      check("R8 rrd", int'(viol_o[6]), int'(d < 3));
      check("R8 no state", int'(viol_o[0]), 0);
    end

    // R9 write recovery
    for (int d = 1; d <= 7; d++) begin
      do_reset(); issue(ACT, 0, 1'b0); idle(11); issue(WR, 0, 1'b0);
      idle(d - 1); issue(PRE, 0, 1'b0);
      check("R9 wr-pre", int'(viol_o[7]), int'(d < 5));
      check("R9 ras fine", int'(viol_o[2]), 0);
    end

    // R10 refresh
    do_reset(); issue(ACT, 0, 1'b0); idle(3); issue(REF, 0, 1'b0);
    check("R10 ref open", int'(viol_o[8]), 1);
    do_reset(); issue(ACT, 0, 1'b0); idle(9); issue(PRE, 0, 1'b0); issue(REF, 0, 1'b0);
    check("R10 ref in rp", int'(viol_o[8]), 1);
    for (int d = 13; d <= 17; d++) begin
      do_reset(); issue(REF, 0, 1'b0);
      check("R10 ref legal", int'(viol_o[8]), 0);
      idle(d - 1); issue(ACT, 2, 1'b0);
      check("R10 ref busy", int'(viol_o[8]), int'(d < 15));
    end
    do_reset(); issue(REF, 0, 1'b0); issue(ACT, 1, 1'b0);
    check("R10 ref busy d1", int'(viol_o[8]), 1);

    // R11 mode write
    for (int d = 1; d <= 3; d++) begin
      do_reset(); issue(MODE, 0, 1'b0);
      check("R11 mode legal", int'(viol_o[9]), 0);
      idle(d - 1); issue(ACT, 0, 1'b0);
      check("R11 mode busy", int'(viol_o[9]), int'(d < 2));
      check("R12 ok mode", int'(cmd_ok_o), int'(d >= 2));
    end
    do_reset(); issue(ACT, 1, 1'b0); idle(2); issue(MODE, 0, 1'b0);
    check("R11 mode open", int'(viol_o[9]), 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL R12 watchdog: actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

endmodule